// File: doc/BRIEF.md
# Three-lane 7:1 parallel-to-serial transmitter

This block turns a 21-bit parallel word into three serial data lanes plus a framing clock lane. On every rising edge of the parallel clock it captures the whole input word. It then sends the word seven bits per lane, one bit per cycle of a bit clock that runs at seven times the parallel rate. The bit clock is phase-locked to the parallel clock but is supplied from outside: no oscillator or loop is built in.

The forwarded clock lane repeats a fixed seven-slot level pattern once per word, so it has the same frequency as the parallel clock. A receiver uses its edges to locate word boundaries. The bit-clock domain watches for parallel-clock rises and re-aligns its slot counter on each one. The first slot of a captured word leaves the block two bit-clock cycles after that rise is seen. An active-low power-down input disables every output through per-lane output-enable signals. After power-down is released, the outputs stay disabled until a complete word has been loaded.

Top module: `ser7_tx`

## Requirements
- R1: After reset, and until the first word load, every output enable (`lane_oe`, `fclk_oe`) is 0 and every data and clock-lane output is 0.
- R2: The input word is captured only on the rising edge of `par_clk`. A change of `par_data` later in the same parallel period does not alter the bits sent for that word.
- R3: Lane k sends input bits 7k+6 down to 7k, MSB first. The bit in slot n of lane k is input bit 7k+6-n.
- R4: Take the first `bit_clk` rising edge at which `par_clk` is seen high after being low. Slot 0 of the word is presented on the outputs after the second `bit_clk` rising edge following that edge. Slots 1 to 6 follow on consecutive bit cycles.
- R5: While enabled, `fclk_dat` carries the levels 1,1,0,0,0,1,1 in slots 0 to 6 of each word, aligned with the data slots.
- R6: While `pdn_n` is 0, all output enables and all data and clock-lane outputs are 0, starting in the same cycle that `pdn_n` falls.
- R7: After `pdn_n` returns to 1, the outputs stay disabled until the first word load. That load is the one following the first `par_clk` rise that is seen with `pdn_n` high.
- R8: Every detected `par_clk` rise re-aligns the slot counter, so the word that follows a stretched parallel period still meets the R4 timing.
- R9: While an output is disabled, its data value is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the parallel rate |
| par_clk | input | 1 | Parallel word clock; its rising edge captures `par_data` |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| pdn_n | input | 1 | Active-low power-down |
| par_data | input | 21 | Parallel input word |
| lane_dat | output | 3 | Serial data lanes, one bit per lane |
| lane_oe | output | 3 | Output enable of each data lane |
| fclk_dat | output | 1 | Forwarded framing clock lane |
| fclk_oe | output | 1 | Output enable of the clock lane |

## Verification
The assertions assume the following:
- `par_clk` changes only between `bit_clk` rising edges, so its level is stable when sampled.
- `pdn_n` is synchronous to `bit_clk`.
- `par_data` is stable at every `par_clk` rise.

The stimulus drives all of these inputs on the falling edge of `bit_clk`. It keeps `par_clk` high for four bit cycles of a seven-cycle period. It stretches only one period on purpose, to exercise the re-alignment in R8. The word patterns sweep walking ones, walking zeros and computed mixed values through every lane slot. Power-down is applied and released only at word boundaries.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

    // Level of the framing clock lane for a given slot: high for the first
    // `head` slots and the last `tail` slots of a word, low in between.
    function automatic logic frame_level(input int unsigned slot,
                                         input int unsigned slots,
                                         input int unsigned head,
                                         input int unsigned tail);
        return (slot < head) || (slot >= slots - tail);
    endfunction

    // Slot counter successor with wrap at the last slot.
    function automatic int unsigned slot_succ(input int unsigned slot,
                                              input int unsigned slots);
        return (slot >= slots - 1) ? 0 : slot + 1;
    endfunction

endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
    parameter int WORD_W = 21
) (
    input  logic              par_clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] par_data,
    output logic [WORD_W-1:0] word_q
);

    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = par_data;
    end

    always_ff @(posedge par_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/ser7_slot_timer.sv
module ser7_slot_timer #(
    parameter int SLOTS = 7,
    parameter int LEAD  = 2,
    localparam int CW   = $clog2(SLOTS)
) (
    input  logic          bit_clk,
    input  logic          rst_n,
    input  logic          par_clk,
    input  logic          pdn_n,
    output logic [CW-1:0] slot,
    output logic          load
);
    import ser7_pkg::*;

    localparam logic [CW-1:0] LAST  = CW'(SLOTS - 1);
    localparam logic [CW-1:0] ALIGN = CW'(SLOTS - LEAD);

    typedef struct packed {
        logic          pclk;
        logic [CW-1:0] slot;
        logic          armed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic rise;

    always_comb begin
        rise  = par_clk & ~tmr_q.pclk;
        load  = tmr_q.armed & pdn_n & ~rise & (tmr_q.slot == LAST);
        tmr_d = tmr_q;
        tmr_d.pclk = par_clk;
        if (rise) begin
            tmr_d.slot = ALIGN;
        end else begin
            tmr_d.slot = CW'(slot_succ(int'(tmr_q.slot), SLOTS));
        end
        if (!pdn_n) begin
            tmr_d.armed = 1'b0;
        end else if (rise) begin
            tmr_d.armed = 1'b1;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot = tmr_q.slot;

    assert_slot_range_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        tmr_q.slot <= LAST);

    assert_realign_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (par_clk && !tmr_q.pclk) |=> (tmr_q.slot == ALIGN));

    assert_load_wrap_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (tmr_q.slot == '0));

    assert_no_load_unarmed_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pdn_n |=> !load);

endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] slice,
    output logic             bit_o
);

    typedef struct packed {
        logic [SLOTS-1:0] sh;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        if (load) begin
            lane_d.sh = slice;
        end else begin
            lane_d.sh = {lane_q.sh[SLOTS-2:0], 1'b0};
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign bit_o = lane_q.sh[SLOTS-1];

    assert_msb_first_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (bit_o == $past(slice[SLOTS-1])));

    assert_shift_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !load |=> (bit_o == $past(lane_q.sh[SLOTS-2])));

endmodule

// File: rtl/ser7_tx.sv
module ser7_tx #(
    parameter int LANES    = 3,
    parameter int SLOTS    = 7,
    parameter int LEAD     = 2,
    parameter int CLK_HEAD = 2,
    parameter int CLK_TAIL = 2,
    localparam int WORD_W  = LANES * SLOTS
) (
    input  logic              bit_clk,
    input  logic              par_clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic [WORD_W-1:0] par_data,
    output logic [LANES-1:0]  lane_dat,
    output logic [LANES-1:0]  lane_oe,
    output logic              fclk_dat,
    output logic              fclk_oe
);
    import ser7_pkg::*;

    localparam int CW = $clog2(SLOTS);

    typedef struct packed {
        logic en;
    } top_t;

    top_t top_d, top_q;

    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     slot;
    logic              load;
    logic [LANES-1:0]  lane_bit;
    logic              live;

    ser7_capture #(.WORD_W(WORD_W)) u_capture (
        .par_clk  (par_clk),
        .rst_n    (rst_n),
        .par_data (par_data),
        .word_q   (word_q)
    );

    ser7_slot_timer #(.SLOTS(SLOTS), .LEAD(LEAD)) u_timer (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .par_clk (par_clk),
        .pdn_n   (pdn_n),
        .slot    (slot),
        .load    (load)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser7_lane #(.SLOTS(SLOTS)) u_lane (
            .bit_clk (bit_clk),
            .rst_n   (rst_n),
            .load    (load),
            .slice   (word_q[k*SLOTS +: SLOTS]),
            .bit_o   (lane_bit[k])
        );
    end

    always_comb begin
        top_d = top_q;
        if (!pdn_n) begin
            top_d.en = 1'b0;
        end else if (load) begin
            top_d.en = 1'b1;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        live     = top_q.en & pdn_n;
        lane_oe  = {LANES{live}};
        lane_dat = lane_bit & {LANES{live}};
        fclk_oe  = live;
        fclk_dat = live & frame_level(int'(slot), SLOTS, CLK_HEAD, CLK_TAIL);
    end

    assert_pdn_clears_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pdn_n |=> !top_q.en);

    assert_enable_on_load_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(top_q.en) |-> $past(load));

    assert_frame_start_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (load && pdn_n) |=> (fclk_dat || !pdn_n));

endmodule

// File: tb/ser7_tx_bench.sv
module ser7_tx_bench;

    logic        bit_clk = 1'b0;
    logic        par_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        pdn_n   = 1'b1;
    logic [20:0] par_data = '0;
    logic [2:0]  lane_dat;
    logic [2:0]  lane_oe;
    logic        fclk_dat;
    logic        fclk_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [20:0] prev_w = '0;
    int          prev_mode = 0;  // 0 disabled, 1 valid, 2 do not check

    always #4 bit_clk = ~bit_clk;  // 125 MHz bit clock

    ser7_tx u_ser7_tx (
        .bit_clk  (bit_clk),
        .par_clk  (par_clk),
        .rst_n    (rst_n),
        .pdn_n    (pdn_n),
        .par_data (par_data),
        .lane_dat (lane_dat),
        .lane_oe  (lane_oe),
        .fclk_dat (fclk_dat),
        .fclk_oe  (fclk_oe)
    );

    function automatic logic frame_exp(input int s);
        return (s < 2) || (s >= 5);
    endfunction

    task automatic all_zero(input string tag);
        checks++;
        if ({lane_dat, lane_oe, fclk_dat, fclk_oe} !== 8'h00) begin
            fails++;
            $display("FAIL %s: outputs dat=%b oe=%b fclk=%b/%b expected all 0",
                     tag, lane_dat, lane_oe, fclk_dat, fclk_oe);
        end
    endtask

    task automatic check_slot(input bit ok, input logic [20:0] w, input int s,
                              input string tag);
        logic [2:0] ed;
        logic       eclk;
        string      t;
        for (int k = 0; k < 3; k++) ed[k] = ok ? w[7*k + 6 - s] : 1'b0;
        eclk = ok ? frame_exp(s) : 1'b0;
        checks += 3;
        if ({lane_oe, fclk_oe} !== {{3{ok}}, ok}) begin
            fails++;
            t = ok ? "R4" : "R7";
            $display("FAIL %s: oe=%b/%b expected %b/%b (slot %0d)",
                     t, lane_oe, fclk_oe, {3{ok}}, ok, s);
        end
        if (lane_dat !== ed) begin
            fails++;
            if (!ok) t = "R9";
            else if (s == 0) t = "R4";
            else t = tag;
            $display("FAIL %s: lane_dat=%b expected %b (word %h slot %0d)",
                     t, lane_dat, ed, w, s);
        end
        if (fclk_dat !== eclk) begin
            fails++;
            t = ok ? "R5" : "R9";
            $display("FAIL %s: fclk_dat=%b expected %b (slot %0d)", t, fclk_dat, eclk, s);
        end
    endtask

    // One parallel period of `period` bit cycles. Checks are made before the
    // inputs are driven at each falling edge.
    task automatic send_word(input logic [20:0] w, input int period, input bit pdn_val,
                             input string tag);
        for (int j = 0; j < period; j++) begin
            @(negedge bit_clk);
            if (j < 3) begin
                if (prev_mode != 2)
                    check_slot((prev_mode == 1) && (j == 0 || pdn_val), prev_w, 4 + j, "R3");
            end else if (j < 7) begin
                check_slot(pdn_val, w, j - 3, tag);
            end
            if (j == 0) begin
                par_data = w;
                pdn_n    = pdn_val;
                par_clk  = 1'b1;
                if (!pdn_val) begin
                    #1;
                    all_zero("R6");
                end
            end
            if (j == 2) par_data = ~w;  // R2: late change must not reach the lanes
            if (j == 4) par_clk = 1'b0;
        end
        prev_w = w;
        if (period != 7) prev_mode = 2;
        else prev_mode = pdn_val ? 1 : 0;
    endtask

    initial begin
        repeat (3) @(negedge bit_clk);
        all_zero("R1");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge bit_clk);
            all_zero("R1");
        end
        send_word(21'h0A5F3C, 7, 1'b1, "R2");
        for (int i = 0; i < 21; i++) send_word(21'(1) << i, 7, 1'b1, "R3");
        for (int i = 0; i < 21; i++) send_word(~(21'(1) << i), 7, 1'b1, "R3");
        for (int i = 0; i < 16; i++)
            send_word(21'((i * 40503 + 12345) ^ (i << 13)), 7, 1'b1, "R2");
        send_word(21'h155555, 9, 1'b1, "R3");   // stretched period
        send_word(21'h0F0F0F, 7, 1'b1, "R8");
        send_word(21'h13579B, 7, 1'b1, "R8");
        send_word(21'h1FFFFF, 7, 1'b0, "R6");
        send_word(21'h1FFFFF, 7, 1'b0, "R6");
        send_word(21'h0C3C3C, 7, 1'b1, "R7");
        send_word(21'h1E1E1E, 7, 1'b1, "R7");
        send_word(21'h000000, 7, 1'b1, "R3");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge bit_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule